// File: doc/BRIEF.md
# Vector Byte-Extract Execution Unit

This unit decodes and runs one SIMD instruction: the byte-window extract. It holds a 32-entry file of 64-bit vector registers. A preload port writes that file, and a read port shows any entry. A 32-bit instruction word comes in with a valid strobe. When the word has the extract encoding, the unit checks the rules that make it undefined. It then reads its source registers, takes a byte-aligned window out of their concatenation and writes the window back, either to one register or to an even/odd register pair.

The short form (Q=0) works on two registers and gives 64 bits. The long form (Q=1) works on two register pairs and gives 128 bits. The start byte picks which registers feed each half of the result. A configuration input limits the file to its lower 16 registers. Every source is read before any result is written, so the destination may be one of the sources. A start byte of 0 or 8 goes through the normal shifter with a shift of zero.

Top module: `vext_unit`

## Requirements
- R1: After reset, done_o and undef_o are 0 and every register reads as zero through rd_addr_i/rd_data_o.
- R2: When wr_en_i is high at a clock edge, wr_data_i is stored at wr_addr_i. rd_data_o shows register rd_addr_i combinationally.
- R3: The extract encoding is insn[31:23]=9'b111100101, insn[21:20]=2'b11 and insn[4]=0. A valid word that does not match raises no done_o and writes no register.
- R4: The fields are D=insn[22], Vn=insn[19:16], Vd=insn[15:12], imm=insn[11:8], N=insn[7], Q=insn[6], M=insn[5] and Vm=insn[3:0]. The register numbers are {D,Vd}, {N,Vn} and {M,Vm}. A matching valid word gives done_o high for exactly the one cycle after the edge that sampled it.
- R5: With Q=0 and imm<8, Vd receives bits [63:0] of {Vm,Vn} >> (imm*8).
- R6: With Q=1 and imm<8, the pair Vd (low half) and Vd+1 (high half) receives bits [127:0] of {Vm+1,Vm,Vn+1,Vn} >> (imm*8).
- R7: With Q=1 and imm>=8, the same 256-bit window rule holds. Vd receives {Vm,Vn+1} >> ((imm-8)*8) and Vd+1 receives {Vm+1,Vm} >> ((imm-8)*8).
- R8: A start byte of 0 or 8 copies whole registers unchanged: Q=0/imm=0 copies Vn, Q=1/imm=0 copies Vn and Vn+1, and Q=1/imm=8 copies Vn+1 and Vm.
- R9: Q=0 with imm>7 is undefined.
- R10: Q=1 with an odd Vd, Vn or Vm is undefined.
- R11: When ext_regs_i is 0, any register number with bit 4 set is undefined. When ext_regs_i is 0 and all numbers are below 16, the instruction runs normally.
- R12: All sources are read before the write, so a destination that overlaps Vn or Vm gives the result computed from the old values.
- R13: An undefined instruction raises undef_o together with done_o and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Preload write enable |
| wr_addr_i | input | 5 | Preload register number |
| wr_data_i | input | 64 | Preload data |
| rd_addr_i | input | 5 | Observation read register number |
| rd_data_o | output | 64 | Observation read data |
| ext_regs_i | input | 1 | 1: all 32 registers exist; 0: only registers 0 to 15 exist |
| insn_valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Undefined instruction, valid while done_o is high |

## Verification
The assertions assume that a preload write never falls in the same cycle as an instruction, or in the cycle just before an observed undefined completion. They also assume that ext_regs_i is held steady while an instruction is sampled. The bench keeps to this: each scenario task finishes its preloads, lets a clock edge pass, and only then presents a single instruction. ext_regs_i is changed only between instructions.

// File: rtl/vext_pkg.sv
package vext_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned RNUM_W = 5;
  localparam int unsigned IMM_W  = 4;
  localparam logic [8:0]  OPC_HI = 9'b1_1110_0101;
  localparam logic [1:0]  OPC_SZ = 2'b11;

  typedef struct packed {
    logic              match;
    logic              undef;
    logic              q;
    logic [IMM_W-1:0]  imm;
    logic [RNUM_W-1:0] vd;
    logic [RNUM_W-1:0] vn;
    logic [RNUM_W-1:0] vm;
  } vext_op_t;
endpackage

// File: rtl/vext_decode.sv
module vext_decode
  import vext_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              ext_regs_i,
  output vext_op_t          op_o
);
  logic odd_any, hi_any;

  always_comb begin
    op_o.match = (insn_i[31:23] == OPC_HI) && (insn_i[21:20] == OPC_SZ) && !insn_i[4];
    op_o.q     = insn_i[6];
    op_o.imm   = insn_i[11:8];
    op_o.vd    = {insn_i[22], insn_i[15:12]};
    op_o.vn    = {insn_i[7],  insn_i[19:16]};
    op_o.vm    = {insn_i[5],  insn_i[3:0]};
    odd_any    = op_o.vd[0] | op_o.vn[0] | op_o.vm[0];
    hi_any     = op_o.vd[RNUM_W-1] | op_o.vn[RNUM_W-1] | op_o.vm[RNUM_W-1];
    op_o.undef = (op_o.q & odd_any)
               | (!op_o.q & op_o.imm[IMM_W-1])
               | (!ext_regs_i & hi_any);
  end
endmodule

// File: rtl/vext_regfile.sv
module vext_regfile #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned NREGS  = 32,
  parameter int unsigned NRD    = 5,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pre_en_i,
  input  logic [AW-1:0]            pre_addr_i,
  input  logic [WORD_W-1:0]        pre_data_i,
  input  logic                     lo_en_i,
  input  logic [AW-1:0]            lo_addr_i,
  input  logic [WORD_W-1:0]        lo_data_i,
  input  logic                     hi_en_i,
  input  logic [AW-1:0]            hi_addr_i,
  input  logic [WORD_W-1:0]        hi_data_i,
  input  logic [NRD-1:0][AW-1:0]   rd_addr_i,
  output logic [NRD-1:0][WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[r] <= '0;
      else if (hi_en_i  && hi_addr_i  == AW'(r))       mem_q[r] <= hi_data_i;
      else if (lo_en_i  && lo_addr_i  == AW'(r))       mem_q[r] <= lo_data_i;
      else if (pre_en_i && pre_addr_i == AW'(r))       mem_q[r] <= pre_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_addr_i[p]];
  end
endmodule

// File: rtl/vext_funnel.sv
module vext_funnel #(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned NBYTE = WORD_W / 8,
  localparam int unsigned SHW   = $clog2(NBYTE)
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [SHW-1:0]    byte_sh_i,
  output logic [WORD_W-1:0] res_o
);
  logic [2*WORD_W-1:0] cat;
  always_comb begin
    cat   = {hi_i, lo_i} >> ({byte_sh_i, 3'b000});
    res_o = cat[WORD_W-1:0];
  end
endmodule

// File: rtl/vext_unit.sv
module vext_unit
  import vext_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned NREGS  = 32,
  localparam int unsigned AW    = $clog2(NREGS),
  localparam int unsigned SHW   = $clog2(WORD_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              ext_regs_i,
  input  logic              insn_valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              done_o,
  output logic              undef_o
);
  localparam int unsigned NRD = 5;
  localparam int unsigned NLANE = 2;

  vext_op_t op;
  logic exec;
  logic [NRD-1:0][AW-1:0]     ra;
  logic [NRD-1:0][WORD_W-1:0] rv;
  logic [WORD_W-1:0] src_n, src_n1, src_m, src_m1;
  logic [NLANE-1:0][WORD_W-1:0] f_hi, f_lo, f_res;
  logic upper;

  vext_decode u_dec (
    .insn_i     (insn_i),
    .ext_regs_i (ext_regs_i),
    .op_o       (op)
  );

  assign exec  = insn_valid_i & op.match & !op.undef;
  assign upper = op.q & op.imm[IMM_W-1];

  always_comb begin
    ra[0] = op.vn[AW-1:0];
    ra[1] = op.vn[AW-1:0] | AW'(1);
    ra[2] = op.vm[AW-1:0];
    ra[3] = op.vm[AW-1:0] | AW'(1);
    ra[4] = rd_addr_i;
  end

  vext_regfile #(.WORD_W(WORD_W), .NREGS(NREGS), .NRD(NRD)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pre_en_i   (wr_en_i),
    .pre_addr_i (wr_addr_i),
    .pre_data_i (wr_data_i),
    .lo_en_i    (exec),
    .lo_addr_i  (op.vd[AW-1:0]),
    .lo_data_i  (f_res[0]),
    .hi_en_i    (exec & op.q),
    .hi_addr_i  (op.vd[AW-1:0] | AW'(1)),
    .hi_data_i  (f_res[1]),
    .rd_addr_i  (ra),
    .rd_data_o  (rv)
  );

  assign src_n  = rv[0];
  assign src_n1 = rv[1];
  assign src_m  = rv[2];
  assign src_m1 = rv[3];
  assign rd_data_o = rv[4];

  // lane 0 -> Vd, lane 1 -> Vd+1; operand pair chosen by form and start byte
  always_comb begin
    if (!op.q)      begin f_hi[0] = src_m;  f_lo[0] = src_n;  end
    else if (upper) begin f_hi[0] = src_m;  f_lo[0] = src_n1; end
    else            begin f_hi[0] = src_n1; f_lo[0] = src_n;  end
    if (upper)      begin f_hi[1] = src_m1; f_lo[1] = src_m;  end
    else            begin f_hi[1] = src_m;  f_lo[1] = src_n1; end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    vext_funnel #(.WORD_W(WORD_W)) u_fun (
      .hi_i      (f_hi[l]),
      .lo_i      (f_lo[l]),
      .byte_sh_i (op.imm[SHW-1:0]),
      .res_o     (f_res[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      undef_o <= 1'b0;
    end else begin
      done_o  <= insn_valid_i & op.match;
      undef_o <= insn_valid_i & op.match & op.undef;
    end
  end
endmodule

// File: rtl/vext_unit_chk.sv
module vext_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [4:0]  rd_addr_i,
  input logic [63:0] rd_data_o,
  input logic        ext_regs_i,
  input logic        insn_valid_i,
  input logic [31:0] insn_i,
  input logic        done_o,
  input logic        undef_o
);
  logic hit;
  assign hit = insn_valid_i && insn_i[31:23] == 9'b111100101 && insn_i[21:20] == 2'b11 && !insn_i[4];

  AST_DONE_AFTER_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> done_o);  // R4
  AST_NO_DONE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> !done_o);  // R3
  AST_UNDEF_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> done_o);  // R13
  AST_SHORT_IMM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !insn_i[6] && insn_i[11]) |=> undef_o);  // R9
  AST_PAIR_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && insn_i[6] && (insn_i[12] || insn_i[16] || insn_i[0])) |=> undef_o);  // R10
  AST_LOW_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !ext_regs_i && (insn_i[22] || insn_i[7] || insn_i[5])) |=> undef_o);  // R11
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && undef_o && $stable(rd_addr_i) && !$past(wr_en_i)) |-> $stable(rd_data_o));  // R13
endmodule

bind vext_unit vext_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .ext_regs_i   (ext_regs_i),
  .insn_valid_i (insn_valid_i),
  .insn_i       (insn_i),
  .done_o       (done_o),
  .undef_o      (undef_o)
);

// File: tb/sim_vext_unit.sv
module sim_vext_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [63:0] rd_data_o;
  logic        ext_regs_i = 1'b1;
  logic        insn_valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        done_o, undef_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [63:0] mdl [32];

  vext_unit u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input bit q, input int imm, input int d, input int n, input int m);
    logic [4:0] dd, nn, mm;
    dd = 5'(d); nn = 5'(n); mm = 5'(m);
    return {9'b111100101, dd[4], 2'b11, nn[3:0], dd[3:0], 4'(imm), nn[4], q, mm[4], 1'b0, mm[3:0]};
  endfunction

  task automatic check_file(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_addr_i = 5'(i);
      #1;
      chk(req, rd_data_o, mdl[i]);
    end
  endtask

  task automatic preload_all();
    for (int i = 0; i < 32; i++) begin
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((i << 3) | k);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 5'(i); wr_data_i = v;
      mdl[i] = v;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  // runs one instruction; expectations derived from the requirement rules
  task automatic run(input string req, input bit q, input int imm, input int d, input int n, input int m);
    logic [255:0] cat;
    logic [127:0] res;
    bit und;
    und = (q && ((d | n | m) & 1) != 0) || (!q && imm > 7) ||
          (!ext_regs_i && ((d | n | m) & 16) != 0);
    if (!q) begin
      cat = {128'b0, mdl[m], mdl[n]} >> (imm * 8);
      res = {64'b0, cat[63:0]};
    end else begin
      cat = {mdl[m | 1], mdl[m], mdl[n | 1], mdl[n]} >> (imm * 8);
      res = cat[127:0];
    end
    @(negedge clk_i);
    insn_i = enc(q, imm, d, n, m);
    insn_valid_i = 1'b1;
    @(negedge clk_i);
    insn_valid_i = 1'b0;
    chk({req, " R4 done"}, 64'(done_o), 64'd1);
    chk({req, " R13 undef"}, 64'(undef_o), 64'(und));
    @(negedge clk_i);
    chk({req, " R4 pulse"}, 64'(done_o), 64'd0);
    if (!und) begin
      mdl[d] = res[63:0];
      if (q) mdl[d | 1] = res[127:64];
    end
    check_file(req);
  endtask

  task automatic t_reset();
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 undef", 64'(undef_o), 64'd0);
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    check_file("R1 file");
  endtask

  task automatic t_preload();
    preload_all();
    check_file("R2 preload");
  endtask

  task automatic t_nomatch();
    @(negedge clk_i);
    insn_i = enc(1'b0, 2, 3, 4, 5) | 32'h10;
    insn_valid_i = 1'b1;
    @(negedge clk_i);
    insn_valid_i = 1'b0;
    chk("R3 no done", 64'(done_o), 64'd0);
    @(negedge clk_i);
    insn_i = enc(1'b0, 2, 3, 4, 5) & ~32'h0030_0000;
    insn_valid_i = 1'b1;
    @(negedge clk_i);
    insn_valid_i = 1'b0;
    chk("R3 no done size", 64'(done_o), 64'd0);
    check_file("R3 no write");
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_ni = 1'b1;
    t_reset();
    t_preload();
    run("R5 short", 1'b0, 3, 5, 2, 9);
    run("R5 short imm7", 1'b0, 7, 6, 11, 30);
    run("R8 short copy", 1'b0, 0, 7, 12, 13);
    run("R6 long", 1'b1, 5, 10, 20, 4);
    run("R8 long imm0", 1'b1, 0, 14, 2, 26);
    run("R8 long imm8", 1'b1, 8, 16, 22, 8);
    run("R7 long upper", 1'b1, 13, 18, 24, 28);
    run("R12 long overlap", 1'b1, 3, 20, 20, 12);
    run("R12 short overlap", 1'b0, 6, 9, 1, 9);
    run("R9 imm range", 1'b0, 9, 3, 4, 5);
    run("R10 odd vm", 1'b1, 2, 4, 6, 7);
    run("R10 odd vd", 1'b1, 2, 5, 6, 8);
    ext_regs_i = 1'b0;
    run("R11 bank", 1'b0, 1, 17, 2, 3);
    run("R11 low ok", 1'b1, 11, 0, 14, 6);
    ext_regs_i = 1'b1;
    t_nomatch();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule